// File: doc/BRIEF.md
# Serial EEPROM Command Controller (SPI Slave)

This block makes a small register-array memory behave like a serial EEPROM on an SPI bus. A host lowers the chip select and then, most significant bit first, sends an 8-bit opcode, an address and data. The block decodes six commands: set the write-enable latch, clear the latch, read the status byte, write the status byte, stream bytes out of the array, and program bytes into it. The SPI pins are oversampled by the system clock through a synchronizer. Bits on SI are taken on rising SCK, and SO changes on falling SCK (mode 0).

Programming is guarded in two ways. A write or status-write opcode is accepted only while the write-enable latch is set, and the latch can be set only while the write-protect pin is high. The data bytes are collected in a page buffer and are committed only if chip select rises on a whole-byte boundary. A commit starts a timed internal write cycle. During that cycle the status byte reads as all ones, every opcode except status read is dropped, and the latch clears when the cycle ends.

Top module: `spi_eeprom_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, and so_en and so are 0 whenever chip select is high.
- R2: Opcode bits 7..4 must be 0000 or the transaction is ignored. Bit 3 is don't-care. Bits 2..0 select the command: 110 set latch, 100 clear latch, 101 status read, 001 status write, 011 array read, 010 array write. The other two codes are ignored.
- R3: The set-latch opcode sets the write-enable latch (status bit 1) only while wp_n is high. The clear-latch opcode clears it at any wp_n level.
- R4: An array write or status write issued while the latch is clear changes neither the array nor the status, and starts no write cycle.
- R5: Outside a write cycle the status byte is {WPEN, 000, BP1, BP0, WEL, 0}, with bits 6..4 and bit 0 read as zero.
- R6: While an internal write cycle runs, the status byte reads 0xFF. The cycle lasts WRITE_CYCLES clocks, after which bit 0 reads 0.
- R7: The write-enable latch is clear once a write cycle ends.
- R8: While a write cycle runs, every opcode other than status read is ignored, including array writes issued with the latch still set.
- R9: A write is committed only if chip select rises after a whole number of data bytes. A partial final byte discards the whole transaction, starts no cycle and leaves the latch set.
- R10: Array read takes a 16-bit address after the opcode and then streams bytes from successive addresses, MSB first, until chip select rises.
- R11: An array write stores up to PAGE_BYTES bytes at consecutive addresses from the given address. Data bytes beyond PAGE_BYTES are dropped.
- R12: Address bits above ADDR_W are ignored, so address 0x1260 reaches location 0x60 when ADDR_W is 8.
- R13: A status write stores only bits 7, 3 and 2 (WPEN, BP1, BP0) and starts a write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock, mode 0 |
| si | input | 1 | Serial data from the host |
| wp_n | input | 1 | Write-protect pin; low blocks latch setting |
| so | output | 1 | Serial data to the host, 0 when not driving |
| so_en | output | 1 | High while so carries read or status data |

## Verification
The opcode path is tried with the plain codes, with bit 3 set, and with a nonzero upper nibble. This separates a decoder that masks the don't-care bit from one that aliases invalid opcodes onto valid ones. Writes are sent with the latch clear, with the latch set, during a running cycle, with a partial final byte, with more bytes than the page holds, and with high address bits set. Each case leaves a different trace in the array that a later streamed read exposes. Status is polled right after a commit and again after the cycle ends. This shows both the all-ones busy value and the cleared latch.

// File: rtl/eeprom_spi_pkg.sv
package eeprom_spi_pkg;

  typedef enum logic [2:0] {
    OP_WRSR  = 3'b001,
    OP_WRITE = 3'b010,
    OP_READ  = 3'b011,
    OP_WRDI  = 3'b100,
    OP_RDSR  = 3'b101,
    OP_WREN  = 3'b110
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_OPC,
    S_STAT,
    S_WRSR,
    S_AHI,
    S_ALO,
    S_RD,
    S_WR,
    S_IGN
  } st_e;

  localparam int unsigned SB_WPEN = 7;
  localparam int unsigned SB_BP1  = 3;
  localparam int unsigned SB_BP0  = 2;
  localparam logic [7:0]  STAT_BUSY_WORD = 8'hFF;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic cs_n_s,
  output logic si_s,
  output logic wp_n_s,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_fall,
  output logic cs_rise
);
  // pin order in the vector: {cs_n, sck, si, wp_n}
  localparam logic [3:0] IDLE_PINS = 4'b1001;

  logic [3:0] stg [STAGES];
  logic [3:0] prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[0] <= IDLE_PINS;
        else     stg[0] <= {cs_n, sck, si, wp_n};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= IDLE_PINS;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev <= IDLE_PINS;
    else     prev <= stg[STAGES-1];
  end

  assign cs_n_s   = stg[STAGES-1][3];
  assign si_s     = stg[STAGES-1][1];
  assign wp_n_s   = stg[STAGES-1][0];
  assign sck_rise =  stg[STAGES-1][2] & ~prev[2];
  assign sck_fall = ~stg[STAGES-1][2] &  prev[2];
  assign cs_fall  = ~stg[STAGES-1][3] &  prev[3];
  assign cs_rise  =  stg[STAGES-1][3] & ~prev[3];

endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/write_timer.sv
module write_timer #(
  parameter int unsigned CYCLES = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int unsigned CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign last = busy && (cnt == '0);

endmodule

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import eeprom_spi_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned PAGE_BYTES   = 8,
  parameter int unsigned WRITE_CYCLES = 400,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  input  logic wp_n,
  output logic so,
  output logic so_en
);
  localparam int unsigned PG_W  = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1);

  // synchronized pins and edges
  logic cs_n_s, si_s, wp_n_s, sck_rise, sck_fall, cs_fall, cs_rise;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .cs_n_s(cs_n_s), .si_s(si_s), .wp_n_s(wp_n_s),
    .sck_rise(sck_rise), .sck_fall(sck_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise)
  );

  st_e              state;
  logic [2:0]       bit_cnt;
  logic [7:0]       shreg;
  logic [7:0]       rx_byte;
  logic             byte_done;
  logic [7:0]       addr_hi;
  logic [15:0]      full_addr;
  logic [ADDR_W-1:0] cur_addr;
  logic             is_rd;
  logic             wel, wpen, bp1, bp0;
  logic [7:0]       wrsr_val;
  logic             wrsr_have;
  logic [7:0]       page_buf [PAGE_BYTES];
  logic [CNT_W-1:0] pg_cnt;
  logic [ADDR_W-1:0] wbase;
  logic             rd_req, rd_vld, stat_load;
  logic [7:0]       rdata;
  logic [7:0]       tx_sh;
  logic [7:0]       status_word;
  logic             busy, cyc_last;
  logic             commit_wr, commit_sr, start_cyc;
  logic [CNT_W-1:0] seq_left;
  logic [PG_W-1:0]  seq_idx;
  logic             mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]       mem_wdata;
  logic             unused_bits;

  assign rx_byte   = {shreg[6:0], si_s};
  assign byte_done = !cs_n_s && sck_rise && (bit_cnt == 3'd7);
  assign full_addr = {addr_hi, rx_byte};
  assign unused_bits = ^{full_addr[15:ADDR_W], wrsr_val[6:4], wrsr_val[1:0]};

  assign status_word = busy ? STAT_BUSY_WORD
                            : {wpen, 3'b000, bp1, bp0, wel, 1'b0};

  // commits are evaluated against the state held when chip select rises
  assign commit_wr = cs_rise && (state == S_WR)   && (bit_cnt == 3'd0) && (pg_cnt != '0);
  assign commit_sr = cs_rise && (state == S_WRSR) && (bit_cnt == 3'd0) && wrsr_have;
  assign start_cyc = commit_wr || commit_sr;

  write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .start(start_cyc), .busy(busy), .last(cyc_last)
  );

  // command engine
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      bit_cnt   <= 3'd0;
      shreg     <= 8'h00;
      addr_hi   <= 8'h00;
      cur_addr  <= '0;
      is_rd     <= 1'b0;
      wel       <= 1'b0;
      wrsr_val  <= 8'h00;
      wrsr_have <= 1'b0;
      pg_cnt    <= '0;
      wbase     <= '0;
      rd_req    <= 1'b0;
      stat_load <= 1'b0;
    end else begin
      rd_req    <= 1'b0;
      stat_load <= 1'b0;
      if (cs_fall) begin
        state     <= S_OPC;
        bit_cnt   <= 3'd0;
        pg_cnt    <= '0;
        wrsr_have <= 1'b0;
      end else if (cs_n_s) begin
        state <= S_IDLE;
      end else if (sck_rise) begin
        shreg   <= rx_byte;
        bit_cnt <= bit_cnt + 3'd1;
        if (byte_done) begin
          unique case (state)
            S_OPC: begin
              if (rx_byte[7:4] != 4'h0) begin
                state <= S_IGN;
              end else if (busy && (rx_byte[2:0] != OP_RDSR)) begin
                state <= S_IGN;
              end else begin
                state <= S_IGN;
                case (rx_byte[2:0])
                  OP_WREN:  if (wp_n_s) wel <= 1'b1;
                  OP_WRDI:  wel <= 1'b0;
                  OP_RDSR:  begin state <= S_STAT; stat_load <= 1'b1; end
                  OP_WRSR:  if (wel) state <= S_WRSR;
                  OP_READ:  begin is_rd <= 1'b1; state <= S_AHI; end
                  OP_WRITE: if (wel) begin is_rd <= 1'b0; state <= S_AHI; end
                  default:  state <= S_IGN;
                endcase
              end
            end
            S_STAT: stat_load <= 1'b1;
            S_WRSR: begin
              if (!wrsr_have) begin
                wrsr_val  <= rx_byte;
                wrsr_have <= 1'b1;
              end
            end
            S_AHI: begin
              addr_hi <= rx_byte;
              state   <= S_ALO;
            end
            S_ALO: begin
              cur_addr <= full_addr[ADDR_W-1:0];
              wbase    <= full_addr[ADDR_W-1:0];
              if (is_rd) begin
                rd_req <= 1'b1;
                state  <= S_RD;
              end else begin
                state  <= S_WR;
              end
            end
            S_RD: begin
              cur_addr <= cur_addr + 1'b1;
              rd_req   <= 1'b1;
            end
            S_WR: begin
              if (pg_cnt < CNT_W'(PAGE_BYTES)) begin
                pg_cnt <= pg_cnt + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
      if (cyc_last) wel <= 1'b0;
    end
  end

  // page buffer: plain storage, no reset needed
  always_ff @(posedge clk) begin
    if (byte_done && (state == S_WR) && (pg_cnt < CNT_W'(PAGE_BYTES)))
      page_buf[pg_cnt[PG_W-1:0]] <= rx_byte;
  end

  // status bits written by a committed status write
  always_ff @(posedge clk) begin
    if (rst) begin
      wpen <= 1'b0;
      bp1  <= 1'b0;
      bp0  <= 1'b0;
    end else if (commit_sr) begin
      wpen <= wrsr_val[SB_WPEN];
      bp1  <= wrsr_val[SB_BP1];
      bp0  <= wrsr_val[SB_BP0];
    end
  end

  // drains the page buffer into the array during the write cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      seq_left <= '0;
      seq_idx  <= '0;
    end else if (commit_wr) begin
      seq_left <= pg_cnt;
      seq_idx  <= '0;
    end else if (seq_left != '0) begin
      seq_left <= seq_left - 1'b1;
      seq_idx  <= seq_idx + 1'b1;
    end
  end

  assign mem_we    = busy && (seq_left != '0);
  assign mem_waddr = wbase + ADDR_W'(seq_idx);
  assign mem_wdata = page_buf[seq_idx];

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(rd_req), .raddr(cur_addr), .rdata(rdata)
  );

  // serial output path
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      tx_sh  <= 8'h00;
      so     <= 1'b0;
      so_en  <= 1'b0;
    end else begin
      rd_vld <= rd_req;
      so_en  <= !cs_n_s && ((state == S_STAT) || (state == S_RD));
      if (stat_load) begin
        tx_sh <= status_word;
      end else if (rd_vld) begin
        tx_sh <= rdata;
      end else if (sck_fall && !cs_n_s) begin
        tx_sh <= {tx_sh[6:0], 1'b0};
      end
      if (cs_n_s) begin
        so <= 1'b0;
      end else if (sck_fall && ((state == S_STAT) || (state == S_RD))) begin
        so <= tx_sh[7];
      end
    end
  end

endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk #(
  parameter int unsigned WRITE_CYCLES = 400
) (
  input logic       clk,
  input logic       rst,
  input logic       cs_n_s,
  input logic       so_en,
  input logic       wp_n_s,
  input logic       wel,
  input logic       busy,
  input logic [7:0] status_word
);
  logic [31:0] busy_len;

  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  assert_so_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !so_en);

  assert_wel_needs_wp_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> $past(wp_n_s));

  assert_cycle_needs_wel_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(wel));

  assert_idle_status_R5: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (status_word[6:4] == 3'b000 && !status_word[0]));

  assert_cycle_length_R6: assert property (@(posedge clk) disable iff (rst)
    busy_len <= WRITE_CYCLES);

  assert_wel_cleared_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  assert_no_set_while_busy_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(wel) |-> !$past(busy));

endmodule

bind spi_eeprom_ctrl spi_eeprom_chk #(.WRITE_CYCLES(WRITE_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .so_en(so_en), .wp_n_s(wp_n_s),
  .wel(wel), .busy(busy), .status_word(status_word)
);

// File: tb/tb_spi_eeprom_ctrl.sv
`timescale 1ns/1ps
module tb_spi_eeprom_ctrl;
  localparam int HALF = 8;          // clk cycles per half SCK period
  localparam int PAGE = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, wp_n = 1'b1;
  logic so, so_en;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  spi_eeprom_ctrl dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sck(sck), .si(si), .wp_n(wp_n),
    .so(so), .so_en(so_en)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      si = tx[i];
      half();
      rx[i] = so;
      sck = 1'b1;
      half();
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    half();
  endtask

  task automatic cs_hi();
    half();
    cs_n = 1'b1;
    repeat (4) half();
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] st);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, st); cs_hi();
  endtask

  task automatic wr(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo(); xfer(8'h02, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) xfer(wbuf[i], d);
    cs_hi();
  endtask

  task automatic rd(input logic [15:0] a, input int n);
    logic [7:0] d;
    cs_lo(); xfer(8'h03, d); xfer(a[15:8], d); xfer(a[7:0], d);
    for (int i = 0; i < n; i++) begin xfer(8'h00, d); rbuf[i] = d; end
    cs_hi();
  endtask

  task automatic wait_ready(output int polls);
    logic [7:0] st;
    polls = 0;
    for (int k = 0; k < 100; k++) begin
      rdsr(st);
      polls++;
      if (!st[0]) break;
    end
  endtask

  task automatic t_reset();
    logic [7:0] st;
    check("R1 so_en idle", {7'b0, so_en}, 8'h00);
    rdsr(st);
    check("R1 reset status", st, 8'h00);
    check("R1 so idle after cs high", {6'b0, so_en, so}, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] st;
    wp_n = 1'b0; cmd1(8'h06); rdsr(st);
    check("R3 set blocked by wp low", st, 8'h00);
    wp_n = 1'b1; cmd1(8'h06); rdsr(st);
    check("R3 set with wp high", st, 8'h02);
    wp_n = 1'b0; cmd1(8'h04); rdsr(st);
    check("R3 clear with wp low", st, 8'h00);
    wp_n = 1'b1; cmd1(8'h0E); rdsr(st);
    check("R2 bit3 dont care", st, 8'h02);
    cmd1(8'h04); cmd1(8'h16); rdsr(st);
    check("R2 nonzero upper nibble ignored", st, 8'h00);
    cmd1(8'h07); rdsr(st);
    check("R2 unused code 111 ignored", st, 8'h00);
  endtask

  task automatic t_write_poll();
    logic [7:0] st;
    int polls;
    cmd1(8'h06);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    wr(16'h0040, 4);
    rdsr(st);
    check("R6 busy status all ones", st, 8'hFF);
    wait_ready(polls);
    check("R6 ready within poll bound", {7'b0, polls < 100}, 8'h01);
    rdsr(st);
    check("R7 latch clear after cycle", st, 8'h00);
    rd(16'h0040, 4);
    check("R10 read byte 0", rbuf[0], 8'h11);
    check("R10 read byte 1", rbuf[1], 8'h22);
    check("R10 read byte 2", rbuf[2], 8'h33);
    check("R10 read byte 3", rbuf[3], 8'h44);
  endtask

  task automatic t_ungated();
    logic [7:0] st;
    wbuf[0] = 8'hA5;
    wr(16'h0040, 1);
    rdsr(st);
    check("R4 no cycle without latch", st, 8'h00);
    rd(16'h0040, 1);
    check("R4 array unchanged", rbuf[0], 8'h11);
    cs_lo(); xfer(8'h01, st); xfer(8'hFF, st); cs_hi();
    rdsr(st);
    check("R4 status write blocked", st, 8'h00);
  endtask

  task automatic t_busy_ignore();
    int polls;
    cmd1(8'h06);
    wbuf[0] = 8'h55;
    wr(16'h0040, 1);
    wbuf[0] = 8'h99;
    wr(16'h0041, 1);           // issued while the cycle runs
    wait_ready(polls);
    rd(16'h0040, 2);
    check("R8 first write landed", rbuf[0], 8'h55);
    check("R8 write during cycle ignored", rbuf[1], 8'h22);
  endtask

  task automatic t_partial();
    logic [7:0] st, d;
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, d); xfer(8'h00, d); xfer(8'h40, d); xfer(8'hAB, d);
    for (int i = 0; i < 3; i++) begin
      si = 1'b1; half(); sck = 1'b1; half(); sck = 1'b0;
    end
    cs_hi();
    rdsr(st);
    check("R9 partial byte no cycle, latch kept", st, 8'h02);
    rd(16'h0040, 1);
    check("R9 partial write discarded", rbuf[0], 8'h55);
    cmd1(8'h04);
  endtask

  task automatic t_addr_hi();
    int polls;
    cmd1(8'h06);
    wbuf[0] = 8'hC3;
    wr(16'h1260, 1);
    wait_ready(polls);
    rd(16'h0060, 1);
    check("R12 upper address bits ignored", rbuf[0], 8'hC3);
  endtask

  task automatic t_page();
    int polls;
    cmd1(8'h06);
    wbuf[0] = 8'h5A;
    wr(16'h0088, 1);
    wait_ready(polls);
    cmd1(8'h06);
    for (int i = 0; i <= PAGE; i++) wbuf[i] = 8'h80 + 8'(i);
    wr(16'h0080, PAGE + 1);
    wait_ready(polls);
    rd(16'h0080, PAGE + 1);
    for (int i = 0; i < PAGE; i++) check("R11 page byte", rbuf[i], 8'h80 + 8'(i));
    check("R11 byte past page dropped", rbuf[PAGE], 8'h5A);
  endtask

  task automatic t_wrsr();
    logic [7:0] st, d;
    int polls;
    cmd1(8'h06);
    cs_lo(); xfer(8'h01, d); xfer(8'hFF, d); cs_hi();
    rdsr(st);
    check("R13 status write starts cycle", st, 8'hFF);
    wait_ready(polls);
    rdsr(st);
    check("R13 only WPEN BP1 BP0 stored", st, 8'h8C);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset();
    t_latch();
    t_write_poll();
    t_ungated();
    t_busy_ignore();
    t_partial();
    t_addr_hi();
    t_page();
    t_wrsr();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule